// File: doc/BRIEF.md
# Operand Bypass and Pipeline Hazard Control

This block watches the register numbers moving through a five-stage in-order pipeline and decides, in the same cycle, how the execute stage should source its two ALU operands and whether the front of the pipeline must hold or discard work. It is purely combinational. The operand multiplexers, register file, pipeline registers and branch comparator sit outside it and consume its outputs directly.

For each execute-stage source operand it picks one of three values: the register file read data, the result held in the memory-stage register, or the result held in the write-back register. A producer qualifies only when it actually writes a register and its destination is not register zero. The nearer (memory-stage) producer wins when both match.

It also detects a load whose result is needed by the instruction right behind it. That case cannot be bypassed, so the block holds the program counter and the fetch/decode register and clears the decode/execute register, which inserts one bubble. A taken branch discards the two younger instructions by clearing both front registers. The branch redirect takes precedence over the load hold, because the instructions that would be held are on the wrong path.

Top module: `hazard_unit_top`

## Requirements
- R1: An operand select is 2'b10 (memory-stage result) when mem_wr_en is 1, mem_wr_dst is nonzero and mem_wr_dst equals that operand's execute source number.
- R2: An operand select is 2'b01 (write-back result) when the memory-stage condition of R1 does not hold for it and wb_wr_en is 1, wb_wr_dst is nonzero and wb_wr_dst equals that operand's execute source number.
- R3: When both the memory-stage and write-back producers qualify for the same operand, the select is 2'b10.
- R4: An operand select is 2'b00 (register file data) when no producer qualifies; a producer whose write enable is 0 or whose destination is register 0 never selects a bypass.
- R5: Operand A uses ex_src_a and drives byp_sel_a; operand B uses ex_src_b and drives byp_sel_b; each select depends only on its own source number.
- R6: The select value 2'b11 is never produced.
- R7: When ex_is_load is 1, branch_taken is 0, and ex_src_b equals dec_src_a or dec_src_b, then hold_pc = 1, hold_fd = 1, clear_de = 1 and clear_fd = 0.
- R8: When branch_taken is 1, clear_fd = 1, clear_de = 1, hold_pc = 0 and hold_fd = 0, whatever the load condition.
- R9: When neither the load condition of R7 nor branch_taken holds, hold_pc, hold_fd, clear_fd and clear_de are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_src_a | input | REG_IDX_W | First source register number of the instruction in execute |
| ex_src_b | input | REG_IDX_W | Second source register number in execute (load destination for loads) |
| dec_src_a | input | REG_IDX_W | First source register number of the instruction in decode |
| dec_src_b | input | REG_IDX_W | Second source register number of the instruction in decode |
| mem_wr_dst | input | REG_IDX_W | Destination register of the instruction in the memory stage |
| mem_wr_en | input | 1 | Register write enable of the instruction in the memory stage |
| wb_wr_dst | input | REG_IDX_W | Destination register of the instruction in write-back |
| wb_wr_en | input | 1 | Register write enable of the instruction in write-back |
| ex_is_load | input | 1 | The instruction in execute reads data memory |
| branch_taken | input | 1 | A branch has been resolved as taken this cycle |
| byp_sel_a | output | 2 | Operand A source: 00 register file, 01 write-back, 10 memory stage |
| byp_sel_b | output | 2 | Operand B source, same encoding |
| hold_pc | output | 1 | Keep the program counter unchanged |
| hold_fd | output | 1 | Keep the fetch/decode register unchanged |
| clear_fd | output | 1 | Clear the fetch/decode register to a no-op |
| clear_de | output | 1 | Clear the decode/execute register to a bubble |

## Verification
Every result of this block is due in the same cycle as the inputs that cause it, with no register on the path, so a change of any input must be reflected on the outputs before the next pipeline clock edge. The bench applies each input pattern, waits a fraction of a clock period for the logic to settle, and samples all outputs well before the next edge, so no check depends on edge ordering. The sweep covers every combination of a small set of register numbers (including register zero) and every combination of the enable and branch flags.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

    // Operand source codes seen by the execute-stage multiplexers.
    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_WBACK   = 2'b01,
        SRC_MEMSTG  = 2'b10
    } opnd_src_e;

    // Front-end pipeline actions for one cycle.
    typedef struct packed {
        logic hold_pc;
        logic hold_fd;
        logic clear_fd;
        logic clear_de;
    } front_ctl_t;

    localparam front_ctl_t FRONT_IDLE     = '{hold_pc: 1'b0, hold_fd: 1'b0,
                                              clear_fd: 1'b0, clear_de: 1'b0};
    localparam front_ctl_t FRONT_BUBBLE   = '{hold_pc: 1'b1, hold_fd: 1'b1,
                                              clear_fd: 1'b0, clear_de: 1'b1};
    localparam front_ctl_t FRONT_REDIRECT = '{hold_pc: 1'b0, hold_fd: 1'b0,
                                              clear_fd: 1'b1, clear_de: 1'b1};

    // Priority choice between the two producers: nearer stage first.
    function automatic opnd_src_e pick_source(input logic mem_hit, input logic wb_hit);
        if (mem_hit)
            return SRC_MEMSTG;
        else if (wb_hit)
            return SRC_WBACK;
        else
            return SRC_REGFILE;
    endfunction

endpackage

// File: rtl/hazard_producer_match.sv
// Decides whether one writing stage supplies a given source register.
module hazard_producer_match #(
    parameter int REG_IDX_W = 5
) (
    input  logic [REG_IDX_W-1:0] src_idx,
    input  logic [REG_IDX_W-1:0] dst_idx,
    input  logic                 dst_wen,
    output logic                 hit
);
    localparam logic [REG_IDX_W-1:0] ZERO_REG = '0;

    always_comb begin
        hit = dst_wen && (dst_idx != ZERO_REG) && (dst_idx == src_idx);
    end
endmodule

// File: rtl/hazard_bypass_pick.sv
// Operand source selection for one execute-stage operand.
module hazard_bypass_pick
    import hazard_pkg::*;
#(
    parameter int REG_IDX_W = 5
) (
    input  logic [REG_IDX_W-1:0] src_idx,
    input  logic [REG_IDX_W-1:0] mem_dst,
    input  logic                 mem_wen,
    input  logic [REG_IDX_W-1:0] wb_dst,
    input  logic                 wb_wen,
    output opnd_src_e            sel
);
    logic mem_hit;
    logic wb_hit;

    hazard_producer_match #(.REG_IDX_W(REG_IDX_W)) u_mem_match (
        .src_idx (src_idx),
        .dst_idx (mem_dst),
        .dst_wen (mem_wen),
        .hit     (mem_hit)
    );

    hazard_producer_match #(.REG_IDX_W(REG_IDX_W)) u_wb_match (
        .src_idx (src_idx),
        .dst_idx (wb_dst),
        .dst_wen (wb_wen),
        .hit     (wb_hit)
    );

    always_comb begin
        sel = pick_source(mem_hit, wb_hit);
    end
endmodule

// File: rtl/hazard_front_ctl.sv
// Load-use bubble insertion and taken-branch redirect for the front end.
module hazard_front_ctl
    import hazard_pkg::*;
#(
    parameter int REG_IDX_W = 5
) (
    input  logic [REG_IDX_W-1:0] load_dst,
    input  logic                 load_in_ex,
    input  logic [REG_IDX_W-1:0] dec_a,
    input  logic [REG_IDX_W-1:0] dec_b,
    input  logic                 redirect,
    output front_ctl_t           ctl
);
    logic uses_load;

    always_comb begin
        uses_load = load_in_ex && ((load_dst == dec_a) || (load_dst == dec_b));
        if (redirect)
            ctl = FRONT_REDIRECT;
        else if (uses_load)
            ctl = FRONT_BUBBLE;
        else
            ctl = FRONT_IDLE;
    end
endmodule

// File: rtl/hazard_unit_top.sv
module hazard_unit_top
    import hazard_pkg::*;
#(
    parameter int REG_IDX_W = 5
) (
    input  logic [REG_IDX_W-1:0] ex_src_a,
    input  logic [REG_IDX_W-1:0] ex_src_b,
    input  logic [REG_IDX_W-1:0] dec_src_a,
    input  logic [REG_IDX_W-1:0] dec_src_b,
    input  logic [REG_IDX_W-1:0] mem_wr_dst,
    input  logic                 mem_wr_en,
    input  logic [REG_IDX_W-1:0] wb_wr_dst,
    input  logic                 wb_wr_en,
    input  logic                 ex_is_load,
    input  logic                 branch_taken,
    output logic [1:0]           byp_sel_a,
    output logic [1:0]           byp_sel_b,
    output logic                 hold_pc,
    output logic                 hold_fd,
    output logic                 clear_fd,
    output logic                 clear_de
);
    localparam int N_OPND = 2;

    logic [REG_IDX_W-1:0] opnd_src [N_OPND];
    opnd_src_e            opnd_sel [N_OPND];
    front_ctl_t           front;

    assign opnd_src[0] = ex_src_a;
    assign opnd_src[1] = ex_src_b;

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        hazard_bypass_pick #(.REG_IDX_W(REG_IDX_W)) u_pick (
            .src_idx (opnd_src[g]),
            .mem_dst (mem_wr_dst),
            .mem_wen (mem_wr_en),
            .wb_dst  (wb_wr_dst),
            .wb_wen  (wb_wr_en),
            .sel     (opnd_sel[g])
        );
    end

    hazard_front_ctl #(.REG_IDX_W(REG_IDX_W)) u_front (
        .load_dst   (ex_src_b),
        .load_in_ex (ex_is_load),
        .dec_a      (dec_src_a),
        .dec_b      (dec_src_b),
        .redirect   (branch_taken),
        .ctl        (front)
    );

    assign byp_sel_a = opnd_sel[0];
    assign byp_sel_b = opnd_sel[1];
    assign hold_pc   = front.hold_pc;
    assign hold_fd   = front.hold_fd;
    assign clear_fd  = front.clear_fd;
    assign clear_de  = front.clear_de;
endmodule

// File: rtl/hazard_unit_checker.sv
module hazard_unit_checker #(
    parameter int REG_IDX_W = 5
) (
    input logic [REG_IDX_W-1:0] ex_src_a,
    input logic [REG_IDX_W-1:0] ex_src_b,
    input logic [REG_IDX_W-1:0] dec_src_a,
    input logic [REG_IDX_W-1:0] dec_src_b,
    input logic [REG_IDX_W-1:0] mem_wr_dst,
    input logic                 mem_wr_en,
    input logic [REG_IDX_W-1:0] wb_wr_dst,
    input logic                 wb_wr_en,
    input logic                 ex_is_load,
    input logic                 branch_taken,
    input logic [1:0]           byp_sel_a,
    input logic [1:0]           byp_sel_b,
    input logic                 hold_pc,
    input logic                 hold_fd,
    input logic                 clear_fd,
    input logic                 clear_de
);
    always_comb begin
        // R6: unused code never appears
        p_no_code3_r6: assert (byp_sel_a != 2'b11 && byp_sel_b != 2'b11);
        // R4: a silent producer never causes a bypass
        p_quiet_no_bypass_r4: assert (mem_wr_en || wb_wr_en ||
                                      (byp_sel_a == 2'b00 && byp_sel_b == 2'b00));
        // R1: memory-stage select only with a real matching writer
        p_mem_sel_source_r1: assert (byp_sel_a != 2'b10 ||
                                     (mem_wr_en && mem_wr_dst != '0 && mem_wr_dst == ex_src_a));
        // R2: write-back select only with a real matching writer
        p_wb_sel_source_r2: assert (byp_sel_b != 2'b01 ||
                                    (wb_wr_en && wb_wr_dst != '0 && wb_wr_dst == ex_src_b));
        // R8: redirect clears both front registers and releases holds
        p_redirect_r8: assert (!branch_taken ||
                               (clear_fd && clear_de && !hold_pc && !hold_fd));
        // R7: the two holds always move together
        p_holds_paired_r7: assert (hold_pc == hold_fd);
        // R9: holds only ever come from a load in execute
        p_hold_needs_load_r9: assert (!hold_pc || ex_is_load);
        // R7: a hold always comes with a bubble in decode/execute
        p_hold_bubble_r7: assert (!hold_pc || (clear_de && !clear_fd));
    end
endmodule

bind hazard_unit_top hazard_unit_checker #(.REG_IDX_W(REG_IDX_W)) u_chk (.*);

// File: tb/hazard_unit_top_test.sv
module hazard_unit_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 5;
    localparam int NV = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [W-1:0] ex_src_a, ex_src_b, dec_src_a, dec_src_b, mem_wr_dst, wb_wr_dst;
    logic mem_wr_en, wb_wr_en, ex_is_load, branch_taken;
    logic [1:0] byp_sel_a, byp_sel_b;
    logic hold_pc, hold_fd, clear_fd, clear_de;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    hazard_unit_top #(.REG_IDX_W(W)) uut (
        .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
        .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
        .mem_wr_dst(mem_wr_dst), .mem_wr_en(mem_wr_en),
        .wb_wr_dst(wb_wr_dst), .wb_wr_en(wb_wr_en),
        .ex_is_load(ex_is_load), .branch_taken(branch_taken),
        .byp_sel_a(byp_sel_a), .byp_sel_b(byp_sel_b),
        .hold_pc(hold_pc), .hold_fd(hold_fd),
        .clear_fd(clear_fd), .clear_de(clear_de)
    );

    // Register numbers used in the sweep: register zero plus a few others.
    function automatic logic [W-1:0] vpick(input int i);
        return W'((i * 7) % 31);
    endfunction

    function automatic logic [1:0] exp_sel(input logic [W-1:0] s);
        if (mem_wr_en && mem_wr_dst != 0 && mem_wr_dst == s) return 2'b10;
        if (wb_wr_en && wb_wr_dst != 0 && wb_wr_dst == s) return 2'b01;
        return 2'b00;
    endfunction

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        ex_src_a = '0; ex_src_b = '0; dec_src_a = '0; dec_src_b = '0;
        mem_wr_dst = '0; wb_wr_dst = '0; mem_wr_en = 0; wb_wr_en = 0;
        ex_is_load = 0; branch_taken = 0;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        settle();
        // Idle state: nothing forwarded, nothing held (R4, R9)
        chk("R4 idle", {byp_sel_a, byp_sel_b}, 4'b0000);
        chk("R9 idle", {hold_pc, hold_fd, clear_fd, clear_de}, 4'b0000);

        // Bypass sweep (R1..R6)
        for (int a = 0; a < NV; a++)
        for (int b = 0; b < NV; b++)
        for (int m = 0; m < NV; m++)
        for (int w = 0; w < NV; w++)
        for (int en = 0; en < 4; en++) begin
            ex_src_a = vpick(a); ex_src_b = vpick(b);
            mem_wr_dst = vpick(m); wb_wr_dst = vpick(w);
            mem_wr_en = en[0]; wb_wr_en = en[1];
            settle();
            chk("R1 R2 R3 R4 operand A", {2'b00, byp_sel_a}, {2'b00, exp_sel(ex_src_a)});
            chk("R5 operand B", {2'b00, byp_sel_b}, {2'b00, exp_sel(ex_src_b)});
            if (byp_sel_a == 2'b11 || byp_sel_b == 2'b11)
                chk("R6 code 11", {byp_sel_a, byp_sel_b}, 4'b0000);
        end

        // Targeted priority case (R3)
        ex_src_a = 5'd9; ex_src_b = 5'd9; mem_wr_dst = 5'd9; wb_wr_dst = 5'd9;
        mem_wr_en = 1; wb_wr_en = 1;
        settle();
        chk("R3 both match", {byp_sel_a, byp_sel_b}, 4'b1010);
        // Register zero never forwarded (R4)
        ex_src_a = 0; ex_src_b = 0; mem_wr_dst = 0; wb_wr_dst = 0;
        settle();
        chk("R4 zero reg", {byp_sel_a, byp_sel_b}, 4'b0000);
        mem_wr_en = 0; wb_wr_en = 0;

        // Front-end sweep (R7..R9)
        for (int lb = 0; lb < NV; lb++)
        for (int da = 0; da < NV; da++)
        for (int db = 0; db < NV; db++)
        for (int f = 0; f < 4; f++) begin
            logic [3:0] e;
            logic use_ld;
            ex_src_b = vpick(lb); dec_src_a = vpick(da); dec_src_b = vpick(db);
            ex_is_load = f[0]; branch_taken = f[1];
            settle();
            use_ld = ex_is_load && (ex_src_b == dec_src_a || ex_src_b == dec_src_b);
            if (branch_taken) begin
                e = 4'b0011;
                chk("R8 redirect", {hold_pc, hold_fd, clear_fd, clear_de}, e);
            end else if (use_ld) begin
                e = 4'b1101;
                chk("R7 load-use", {hold_pc, hold_fd, clear_fd, clear_de}, e);
            end else begin
                e = 4'b0000;
                chk("R9 no hazard", {hold_pc, hold_fd, clear_fd, clear_de}, e);
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule